// File: doc/BRIEF.md
# Paired-Page TLB Entry Array

This block is the register-based entry store of a translation lookaside buffer in which every entry maps a pair of adjacent virtual pages. An entry holds a page mask, a high word (the virtual page pair number and address-space identifier) and two low words, one for the even page and one for the odd page. Software stages a full entry in four staging words outside the block. It then issues one of three one-cycle commands: an indexed write, a write to a pseudo-random slot, or an indexed read that returns a formatted copy of the entry.

The global attribute is held once per entry, as a bit of the stored high word. That bit is the AND of the global bits of the two staged low words. On a read the bit is copied back into both low words. A replacement counter runs down on every clock. It gives the slot for random writes and never points at one of the wired entries below the wired count. Lookup and the translation datapath sit elsewhere.

Top module: `tlb_pair_array`

## Requirements
- R1: While `rst_ni` is low and at the first edge after it, `random_o` is 15, `rd_valid_o` is 0, all four read outputs are 0 and every entry reads back as all zeros.
- R2: An indexed write (`wr_i`) stores the entry at `index_i` as given, with no range check. The stored high word is `stg_hi_i` with every bit set in `stg_pgmask_i` cleared.
- R3: On any write, the entry is global when bit 0 of both `stg_lo0_i` and `stg_lo1_i` is 1, and only then. The global flag is kept in bit 12 of the stored high word, which replaces the staged bit 12.
- R4: A read (`rd_i`) returns the entry's stored page mask on `rd_pgmask_o`.
- R5: A read returns the stored high word on `rd_hi_o` with the page-mask bits and bit 12 cleared.
- R6: A read returns both low words with bit 0 forced to 1 if the entry is global and to 0 if it is not. Bits 31:1 are returned as they were written.
- R7: Read results appear on the outputs one clock after `rd_i`. `rd_valid_o` is high for exactly that cycle, and the outputs hold until the next read.
- R8: `random_o` counts down by one per clock. When it is at or below `wired_i` it reloads 15 instead. After one clock it is never below the previous cycle's `wired_i`, and it changes every clock unless `wired_i` is 15.
- R9: A random write (`wr_rand_i`) stores the staged entry at the slot shown on `random_o` in that cycle.
- R10: When `wr_i` and `wr_rand_i` are both high, only the indexed write happens. A read in the same cycle as a write to the same slot returns the contents from before that write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| index_i | input | 4 | Slot for indexed read and write |
| wired_i | input | 4 | Number of wired entries kept out of random replacement |
| stg_pgmask_i | input | 32 | Staged page mask |
| stg_hi_i | input | 32 | Staged high word |
| stg_lo0_i | input | 32 | Staged even-page low word, bit 0 global |
| stg_lo1_i | input | 32 | Staged odd-page low word, bit 0 global |
| rd_i | input | 1 | Indexed read strobe |
| wr_i | input | 1 | Indexed write strobe |
| wr_rand_i | input | 1 | Random write strobe |
| rd_valid_o | output | 1 | Read data updated this cycle |
| rd_pgmask_o | output | 32 | Read page mask |
| rd_hi_o | output | 32 | Read high word |
| rd_lo0_o | output | 32 | Read even-page low word |
| rd_lo1_o | output | 32 | Read odd-page low word |
| random_o | output | 4 | Current random replacement slot |

## Verification
A wrong replacement counter is visible on `random_o` in the cycle after the bad step. A skipped wrap or a slot inside the wired region therefore shows up within one clock. A wrong stored entry stays hidden until that slot is read. The bench reads back every slot after each group of writes, so a corrupted global flag, a mask that was not cleared or a misdirected random write shows up one cycle after the read that covers it. Because read outputs hold their value, a read-register fault is also compared on every following cycle until the next read.

// File: rtl/tlb_pair_pkg.sv
package tlb_pair_pkg;
  localparam int TLB_DW = 32;

  typedef struct packed {
    logic [TLB_DW-1:0] pgmask;
    logic [TLB_DW-1:0] hi;
    logic [TLB_DW-1:0] lo0;
    logic [TLB_DW-1:0] lo1;
  } tlb_entry_t;

  typedef enum logic [1:0] {
    WSEL_NONE = 2'd0,
    WSEL_IDX  = 2'd1,
    WSEL_RAND = 2'd2
  } wsel_e;
endpackage

// File: rtl/tlb_rand_ctr.sv
module tlb_rand_ctr #(
  parameter int N_ENTRIES = 16,
  parameter int IDX_W     = $clog2(N_ENTRIES)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [IDX_W-1:0] wired_i,
  output logic [IDX_W-1:0] rnd_o
);
  localparam logic [IDX_W-1:0] TOP = IDX_W'(N_ENTRIES - 1);

  logic [IDX_W-1:0] rnd_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)               rnd_q <= TOP;
    else if (rnd_q <= wired_i) rnd_q <= TOP;
    else                       rnd_q <= rnd_q - 1'b1;
  end

  assign rnd_o = rnd_q;
endmodule

// File: rtl/tlb_write_fmt.sv
module tlb_write_fmt
  import tlb_pair_pkg::*;
#(
  parameter int HI_G_BIT = 12,
  parameter int LO_G_BIT = 0
) (
  input  logic [TLB_DW-1:0] pgmask_i,
  input  logic [TLB_DW-1:0] hi_i,
  input  logic [TLB_DW-1:0] lo0_i,
  input  logic [TLB_DW-1:0] lo1_i,
  output tlb_entry_t        ent_o
);
  logic glob;

  always_comb begin
    glob              = lo0_i[LO_G_BIT] & lo1_i[LO_G_BIT];
    ent_o.pgmask      = pgmask_i;
    ent_o.hi          = hi_i & ~pgmask_i;
    ent_o.hi[HI_G_BIT]= glob;
    ent_o.lo0         = lo0_i;
    ent_o.lo0[LO_G_BIT] = 1'b0;
    ent_o.lo1         = lo1_i;
    ent_o.lo1[LO_G_BIT] = 1'b0;
  end
endmodule

// File: rtl/tlb_read_fmt.sv
module tlb_read_fmt
  import tlb_pair_pkg::*;
#(
  parameter int HI_G_BIT = 12,
  parameter int LO_G_BIT = 0
) (
  input  tlb_entry_t ent_i,
  output tlb_entry_t view_o
);
  logic glob;

  always_comb begin
    glob                 = ent_i.hi[HI_G_BIT];
    view_o.pgmask        = ent_i.pgmask;
    view_o.hi            = ent_i.hi & ~ent_i.pgmask;
    view_o.hi[HI_G_BIT]  = 1'b0;
    view_o.lo0           = ent_i.lo0;
    view_o.lo0[LO_G_BIT] = glob;
    view_o.lo1           = ent_i.lo1;
    view_o.lo1[LO_G_BIT] = glob;
  end
endmodule

// File: rtl/tlb_entry_store.sv
module tlb_entry_store
  import tlb_pair_pkg::*;
#(
  parameter int N_ENTRIES = 16,
  parameter int IDX_W     = $clog2(N_ENTRIES)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             we_i,
  input  logic [IDX_W-1:0] waddr_i,
  input  tlb_entry_t       wdata_i,
  input  logic [IDX_W-1:0] raddr_i,
  output tlb_entry_t       rdata_o
);
  tlb_entry_t mem [N_ENTRIES];

  for (genvar g = 0; g < N_ENTRIES; g++) begin : g_ent
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)                                 mem[g] <= '0;
      else if (we_i && (waddr_i == IDX_W'(g)))     mem[g] <= wdata_i;
    end
  end

  // slots beyond N_ENTRIES read as zero
  always_comb begin
    rdata_o = '0;
    if (int'(raddr_i) < N_ENTRIES) rdata_o = mem[raddr_i];
  end
endmodule

// File: rtl/tlb_pair_array.sv
module tlb_pair_array
  import tlb_pair_pkg::*;
#(
  parameter int N_ENTRIES = 16,
  parameter int IDX_W     = $clog2(N_ENTRIES),
  parameter int DATA_W    = TLB_DW,
  parameter int HI_G_BIT  = 12,
  parameter int LO_G_BIT  = 0
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [IDX_W-1:0]  index_i,
  input  logic [IDX_W-1:0]  wired_i,
  input  logic [DATA_W-1:0] stg_pgmask_i,
  input  logic [DATA_W-1:0] stg_hi_i,
  input  logic [DATA_W-1:0] stg_lo0_i,
  input  logic [DATA_W-1:0] stg_lo1_i,
  input  logic              rd_i,
  input  logic              wr_i,
  input  logic              wr_rand_i,
  output logic              rd_valid_o,
  output logic [DATA_W-1:0] rd_pgmask_o,
  output logic [DATA_W-1:0] rd_hi_o,
  output logic [DATA_W-1:0] rd_lo0_o,
  output logic [DATA_W-1:0] rd_lo1_o,
  output logic [IDX_W-1:0]  random_o
);
  logic [IDX_W-1:0] rnd;
  logic [IDX_W-1:0] waddr;
  wsel_e            wsel;
  tlb_entry_t       wdata, rdata, rview, rd_q;
  logic             rd_valid_q;

  tlb_rand_ctr #(.N_ENTRIES(N_ENTRIES), .IDX_W(IDX_W)) u_rnd (
    .clk_i(clk_i), .rst_ni(rst_ni), .wired_i(wired_i), .rnd_o(rnd)
  );

  tlb_write_fmt #(.HI_G_BIT(HI_G_BIT), .LO_G_BIT(LO_G_BIT)) u_wfmt (
    .pgmask_i(stg_pgmask_i), .hi_i(stg_hi_i), .lo0_i(stg_lo0_i),
    .lo1_i(stg_lo1_i), .ent_o(wdata)
  );

  // indexed write wins over random write
  always_comb begin
    if (wr_i)           wsel = WSEL_IDX;
    else if (wr_rand_i) wsel = WSEL_RAND;
    else                wsel = WSEL_NONE;
    waddr = (wsel == WSEL_IDX) ? index_i : rnd;
  end

  tlb_entry_store #(.N_ENTRIES(N_ENTRIES), .IDX_W(IDX_W)) u_store (
    .clk_i(clk_i), .rst_ni(rst_ni), .we_i(wsel != WSEL_NONE),
    .waddr_i(waddr), .wdata_i(wdata), .raddr_i(index_i), .rdata_o(rdata)
  );

  tlb_read_fmt #(.HI_G_BIT(HI_G_BIT), .LO_G_BIT(LO_G_BIT)) u_rfmt (
    .ent_i(rdata), .view_o(rview)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rd_q       <= '0;
      rd_valid_q <= 1'b0;
    end else begin
      rd_valid_q <= rd_i;
      if (rd_i) rd_q <= rview;
    end
  end

  assign rd_valid_o  = rd_valid_q;
  assign rd_pgmask_o = rd_q.pgmask;
  assign rd_hi_o     = rd_q.hi;
  assign rd_lo0_o    = rd_q.lo0;
  assign rd_lo1_o    = rd_q.lo1;
  assign random_o    = rnd;
endmodule

// File: rtl/tlb_pair_array_chk.sv
module tlb_pair_array_chk #(
  parameter int N_ENTRIES = 16,
  parameter int IDX_W     = 4,
  parameter int DATA_W    = 32,
  parameter int HI_G_BIT  = 12,
  parameter int LO_G_BIT  = 0
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic [IDX_W-1:0]  wired_i,
  input logic              rd_i,
  input logic              rd_valid_o,
  input logic [DATA_W-1:0] rd_pgmask_o,
  input logic [DATA_W-1:0] rd_hi_o,
  input logic [DATA_W-1:0] rd_lo0_o,
  input logic [DATA_W-1:0] rd_lo1_o,
  input logic [IDX_W-1:0]  random_o
);
  localparam logic [IDX_W-1:0] TOP = IDX_W'(N_ENTRIES - 1);

  // R8
  rnd_above_wired_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    1'b1 |=> random_o >= $past(wired_i));

  // R8
  rnd_moves_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wired_i != TOP) |=> random_o != $past(random_o));

  // R7
  rd_valid_follows_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rd_i |=> rd_valid_o);

  // R7
  rd_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !rd_i |=> !rd_valid_o && $stable(rd_hi_o) && $stable(rd_lo0_o));

  // R5
  rd_hi_clean_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rd_valid_o |-> ((rd_hi_o & rd_pgmask_o) == '0) && !rd_hi_o[HI_G_BIT]);

  // R6
  rd_g_pair_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rd_valid_o |-> rd_lo0_o[LO_G_BIT] == rd_lo1_o[LO_G_BIT]);
endmodule

bind tlb_pair_array tlb_pair_array_chk #(
  .N_ENTRIES(N_ENTRIES), .IDX_W(IDX_W), .DATA_W(DATA_W),
  .HI_G_BIT(HI_G_BIT), .LO_G_BIT(LO_G_BIT)
) u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .wired_i(wired_i), .rd_i(rd_i),
  .rd_valid_o(rd_valid_o), .rd_pgmask_o(rd_pgmask_o), .rd_hi_o(rd_hi_o),
  .rd_lo0_o(rd_lo0_o), .rd_lo1_o(rd_lo1_o), .random_o(random_o)
);

// File: tb/tlb_pair_array_test.sv
module tlb_pair_array_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [3:0]  index = '0, wired = '0;
  logic [31:0] s_pm = '0, s_hi = '0, s_lo0 = '0, s_lo1 = '0;
  logic        rd = 1'b0, wr = 1'b0, wr_rand = 1'b0;
  logic        rd_valid;
  logic [31:0] o_pm, o_hi, o_lo0, o_lo1;
  logic [3:0]  rnd;

  int n_chk = 0, n_fail = 0;
  string cur_req = "R1";
  bit done = 1'b0;

  always #10 clk = ~clk;

  tlb_pair_array uut (
    .clk_i(clk), .rst_ni(rst_n), .index_i(index), .wired_i(wired),
    .stg_pgmask_i(s_pm), .stg_hi_i(s_hi), .stg_lo0_i(s_lo0), .stg_lo1_i(s_lo1),
    .rd_i(rd), .wr_i(wr), .wr_rand_i(wr_rand), .rd_valid_o(rd_valid),
    .rd_pgmask_o(o_pm), .rd_hi_o(o_hi), .rd_lo0_o(o_lo0), .rd_lo1_o(o_lo1),
    .random_o(rnd)
  );

  // reference model
  logic [31:0] m_pm [16], m_hi [16], m_lo0 [16], m_lo1 [16];
  logic [31:0] e_pm, e_hi, e_lo0, e_lo1;
  logic        e_valid;
  int          m_rnd;

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int k = 0; k < 16; k++) begin
        m_pm[k] <= 0; m_hi[k] <= 0; m_lo0[k] <= 0; m_lo1[k] <= 0;
      end
      e_pm <= 0; e_hi <= 0; e_lo0 <= 0; e_lo1 <= 0; e_valid <= 0;
      m_rnd <= 15;
    end else begin
      int t;
      bit g;
      e_valid <= rd;
      if (rd) begin
        g = m_hi[index][12];
        e_pm  <= m_pm[index];
        e_hi  <= m_hi[index] & ~m_pm[index] & ~32'h1000;
        e_lo0 <= {m_lo0[index][31:1], g};
        e_lo1 <= {m_lo1[index][31:1], g};
      end
      if (wr || wr_rand) begin
        t = wr ? int'(index) : m_rnd;
        g = s_lo0[0] && s_lo1[0];
        m_pm[t]  <= s_pm;
        m_hi[t]  <= (s_hi & ~s_pm & ~32'h1000) | (g ? 32'h1000 : 32'h0);
        m_lo0[t] <= s_lo0 & ~32'h1;
        m_lo1[t] <= s_lo1 & ~32'h1;
      end
      m_rnd <= (m_rnd <= int'(wired)) ? 15 : m_rnd - 1;
    end
  end

  task automatic chk(string fld, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s [%s] actual=%h expected=%h at %0t", cur_req, fld, act, exp, $time);
    end
  endtask

  always @(negedge clk) begin
    if (!done) begin
      chk("R8 random_o", {28'h0, rnd}, m_rnd[31:0]);
      chk("R7 rd_valid_o", {31'h0, rd_valid}, {31'h0, e_valid});
      chk("R4 rd_pgmask_o", o_pm, e_pm);
      chk("R5 rd_hi_o", o_hi, e_hi);
      chk("R6 rd_lo0_o", o_lo0, e_lo0);
      chk("R6 rd_lo1_o", o_lo1, e_lo1);
    end
  end

  task automatic cyc(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic stage(logic [31:0] pm, hi, lo0, lo1);
    s_pm = pm; s_hi = hi; s_lo0 = lo0; s_lo1 = lo1;
  endtask

  task automatic do_write(logic [3:0] i, logic [31:0] pm, hi, lo0, lo1);
    stage(pm, hi, lo0, lo1); index = i; wr = 1'b1;
    cyc(1); wr = 1'b0;
  endtask

  task automatic do_rwrite(logic [31:0] pm, hi, lo0, lo1);
    stage(pm, hi, lo0, lo1); wr_rand = 1'b1;
    cyc(1); wr_rand = 1'b0;
  endtask

  task automatic do_read(logic [3:0] i);
    index = i; rd = 1'b1;
    cyc(1); rd = 1'b0;
  endtask

  task automatic read_all();
    for (int k = 0; k < 16; k++) begin
      do_read(4'(k)); cyc(1);
    end
  endtask

  task automatic finish_run();
    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", n_chk, n_fail);
    $finish;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    // R1: reset state and all-zero entries
    cur_req = "R1";
    cyc(3);
    rst_n = 1'b1;
    cyc(1);
    read_all();

    // R2: indexed writes clear page-mask bits of the high word
    cur_req = "R2";
    for (int k = 0; k < 16; k++)
      do_write(4'(k), 32'h0001_e000 << (k % 4), 32'hdead_beef ^ (k * 32'h1111_0101),
               32'h1234_5670 + k, 32'h8765_4320 + k);
    read_all();

    // R3: global only when both staged low bits are set; staged bit 12 is replaced
    cur_req = "R3";
    do_write(4'd1, 32'h0, 32'hffff_f0ff, 32'h0000_0011, 32'h0000_0021);
    do_write(4'd2, 32'h0, 32'hffff_ffff, 32'h0000_0011, 32'h0000_0020);
    do_write(4'd3, 32'h0, 32'hffff_ffff, 32'h0000_0010, 32'h0000_0021);
    do_write(4'd4, 32'h0000_6000, 32'h0000_1abc, 32'h0000_0010, 32'h0000_0020);
    do_write(4'd5, 32'hffff_ffff, 32'hffff_ffff, 32'hffff_ffff, 32'hffff_ffff);
    for (int k = 1; k <= 5; k++) begin
      do_read(4'(k)); cyc(1);
    end

    // R8: counter walks down and reloads at the wired count
    cur_req = "R8";
    wired = 4'd0; cyc(40);
    wired = 4'd15; cyc(5);
    wired = 4'd6; cyc(25);
    wired = 4'd13; cyc(8);
    wired = 4'd2; cyc(3);
    wired = 4'd11; cyc(10);

    // R9: random writes land on the current random slot
    cur_req = "R9";
    wired = 4'd4;
    for (int k = 0; k < 20; k++) begin
      do_rwrite(32'h0000_2000, 32'h4000_0000 + (k << 16), 32'h0000_1001 + (k << 4),
                32'h0000_2001 + (k << 4));
      cyc(k % 3);
    end
    wired = 4'd0;
    read_all();

    // R10: indexed write has priority; read sees pre-write contents
    cur_req = "R10";
    index = 4'd7;
    stage(32'h0, 32'h7777_0000, 32'h0000_0771, 32'h0000_0781);
    wr = 1'b1; wr_rand = 1'b1;
    cyc(1); wr = 1'b0; wr_rand = 1'b0;
    stage(32'h0, 32'haaaa_0000, 32'h0000_0aa0, 32'h0000_0ab0);
    index = 4'd7; rd = 1'b1; wr = 1'b1;
    cyc(1); rd = 1'b0; wr = 1'b0;
    cyc(1);
    read_all();

    // R7: outputs hold over idle cycles after a read
    cur_req = "R7";
    do_read(4'd9); cyc(6);
    do_read(4'd7); do_read(4'd1); cyc(4);

    finish_run();
  end
endmodule